// File: doc/BRIEF.md
# Regulator Fault Supervisor with Retry Counter

This block sits between the comparators that watch a set of power rails and the sequencer that brings those rails up. It takes one-bit fault flags and decides, on each new fault, whether every regulator should be switched off for a single retry or switched off for good. Over-voltage on the memory core rail or on the memory termination rail latches the block off at once, and so does the over-temperature flag. Under-voltage on any rail and over-current on the memory core rail are counted faults. Each one turns every regulator off for one cycle and then asks the sequencer to run its normal bring-up again. Rails that are already regulating are the sequencer's concern, not this block's.

Two counters work together. The retry counter adds one on every accepted counted fault, and the fourth fault latches the block off. The quiet-window timer runs on soft-start period ticks while the retry counter is non-zero. Any counted fault restarts it, and after nine ticks with no new fault it returns the retry counter to zero. A latched-off state is left only when the active-low S5 sleep input goes low and then comes back high. That return to high also clears both counters.

All fault flags are level signals, and the block reacts only to their rising edges. The handshake with the sequencer is a plain pair of pulses. There is no stream interface, and so there is no back-pressure.

Top module: `fault_supervisor`

## Requirements
- R1: Out of reset, `shutdown`, `restart_req` and `latched_off` are all low.
- R2: A rising edge on `ov_core`, `ov_term` or `therm_hot` sets `latched_off` and `shutdown` high on the next clock edge, and `restart_req` is not raised for that fault.
- R3: Once set, `latched_off` (and with it `shutdown`) stays high until a clock edge that samples `slp_s5_n` high after it was sampled low. That edge clears `latched_off`, the retry count and the window timer. Counted faults that arrive while latched change nothing.
- R4: A rising edge on any bit of `uv_flags`, or on `oc_core`, while not latched makes `shutdown` high for exactly one cycle, starting at the next clock edge. `restart_req` is then high for exactly one cycle, the cycle after that.
- R5: The retry count goes up by one per accepted counted fault and never exceeds 4. The counted fault that brings it to 4 latches the block off (R3 rules) and produces no `restart_req`.
- R6: While the retry count is non-zero and the block is not latched, each cycle with `ss_tick` high advances the window timer, and the ninth such tick clears the count. A counted fault sets the timer back to zero, so eight ticks are not enough.
- R7: A flag that stays high is counted once. It must fall and rise again before it can cause another shutdown.
- R8: When a latching fault and a counted fault rise in the same cycle, the block latches, issues no `restart_req`, and does not add to the retry count.
- R9: A fault that rises in the same cycle as the S5 release (the high sample of `slp_s5_n` after a low one) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flags | input | NUM_UV | Per-rail under-voltage flags, one bit per rail |
| oc_core | input | 1 | Over-current flag of the memory core rail |
| ov_core | input | 1 | Over-voltage flag of the memory core rail |
| ov_term | input | 1 | Over-voltage flag of the memory termination rail |
| therm_hot | input | 1 | Over-temperature flag |
| slp_s5_n | input | 1 | Active-low S5 sleep request; a low then high sequence releases a latch |
| ss_tick | input | 1 | One-cycle pulse at each soft-start period |
| shutdown | output | 1 | Turns all regulators off (one-cycle pulse on retry, held while latched) |
| restart_req | output | 1 | One-cycle request to the sequencer to rerun bring-up |
| latched_off | output | 1 | High while the block is permanently off |

## Verification
The retry path is driven with single-cycle faults on different under-voltage bits and on the over-current flag. This separates a correct count-to-four from an off-by-one, and a long-held flag shows whether counting is by edge or by level. The quiet window is tested with eight ticks followed by a fault, which must still latch, and with nine ticks, which must clear the count. A sequence of fault, five ticks, fault, five ticks shows whether a fault restarts the timer. Each latching source, a latching fault together with a counted one, and a fault in the same cycle as the S5 release cover the priority rules. A behavioural model compares all three outputs on every cycle.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // Event class resolved once per cycle, highest priority first: clear, latch, count.
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_COUNTED  = 2'd1,
    EV_LATCHING = 2'd2,
    EV_CLEAR    = 2'd3
  } fsup_ev_e;
endpackage

// File: rtl/fsup_edge.sv
module fsup_edge #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VEC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[i] <= RST_VEC[i];
        else        prev_q[i] <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q[i];

      // R7: a held level yields a single rising event
      a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> !rise[i]);
    end
  endgenerate
endmodule

// File: rtl/fsup_count.sv
module fsup_count
  import fsup_pkg::*;
#(
  parameter int LIMIT  = 4,
  parameter int WINDOW = 9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  fsup_ev_e ev,
  input  logic     latched,
  input  logic     tick,
  output logic     accept,
  output logic     limit_hit
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam int TMR_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WINDOW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;
  logic             win_run;

  assign accept    = (ev == EV_COUNTED) && !latched;
  assign limit_hit = accept && (cnt_q == CNT_LAST);
  assign win_run   = tick && !latched && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (ev == EV_CLEAR) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (accept) begin
      cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      tmr_q <= '0;
    end else if (win_run) begin
      if (tmr_q == TMR_LAST) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  // R5: the retry count saturates at the limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R6: a completed quiet window empties the count
  a_r6_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE && win_run && tmr_q == TMR_LAST) |=> (cnt_q == '0));
  // R6: an accepted fault restarts the window
  a_r6_fault_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tmr_q == '0));
endmodule

// File: rtl/fsup_latch.sv
module fsup_latch
  import fsup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fsup_ev_e ev,
  input  logic     accept,
  input  logic     limit_hit,
  output logic     latched_q,
  output logic     pulse_q,
  output logic     restart_q
);
  logic latch_nxt;

  always_comb begin
    if (ev == EV_CLEAR) latch_nxt = 1'b0;
    else                latch_nxt = latched_q | (ev == EV_LATCHING) | limit_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      pulse_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      latched_q <= latch_nxt;
      pulse_q   <= accept & ~limit_hit;
      restart_q <= pulse_q & ~latch_nxt;
    end
  end

  // R2: a latching event always lands in the latched state
  a_r2_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_LATCHING) |=> latched_q);
  // R3: only the S5 release leaves the latched state
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && ev != EV_CLEAR) |=> latched_q);
  // R4: a restart request follows a one-cycle shutdown pulse
  a_r4_restart_order: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> $past(pulse_q));
  // R8: no restart request while latched
  a_r8_no_restart_latched: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> !latched_q);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int NUM_UV      = 5,
  parameter int FAULT_LIMIT = 4,
  parameter int QUIET_TICKS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_UV-1:0] uv_flags,
  input  logic              oc_core,
  input  logic              ov_core,
  input  logic              ov_term,
  input  logic              therm_hot,
  input  logic              slp_s5_n,
  input  logic              ss_tick,
  output logic              shutdown,
  output logic              restart_req,
  output logic              latched_off
);
  localparam int FW = NUM_UV + 5;
  localparam int OC_B = NUM_UV;
  localparam int OVC_B = NUM_UV + 1;
  localparam int OVT_B = NUM_UV + 2;
  localparam int HOT_B = NUM_UV + 3;
  localparam int S5_B = NUM_UV + 4;
  // The S5 input idles high, so its history starts high to avoid a false release.
  localparam logic [FW-1:0] EDGE_RST = {1'b1, {(FW-1){1'b0}}};

  logic [FW-1:0] lvl, rise;
  logic          counted_r, latching_r, release_r;
  fsup_ev_e      ev;
  logic          accept, limit_hit, pulse_q;

  assign lvl = {slp_s5_n, therm_hot, ov_term, ov_core, oc_core, uv_flags};

  fsup_edge #(.W(FW), .RST_VEC(EDGE_RST)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl),
    .rise (rise)
  );

  assign counted_r  = (|rise[NUM_UV-1:0]) | rise[OC_B];
  assign latching_r = rise[OVC_B] | rise[OVT_B] | rise[HOT_B];
  assign release_r  = rise[S5_B];

  always_comb begin
    if (release_r)       ev = EV_CLEAR;
    else if (latching_r) ev = EV_LATCHING;
    else if (counted_r)  ev = EV_COUNTED;
    else                 ev = EV_NONE;
  end

  fsup_count #(.LIMIT(FAULT_LIMIT), .WINDOW(QUIET_TICKS)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .latched  (latched_off),
    .tick     (ss_tick),
    .accept   (accept),
    .limit_hit(limit_hit)
  );

  fsup_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .accept   (accept),
    .limit_hit(limit_hit),
    .latched_q(latched_off),
    .pulse_q  (pulse_q),
    .restart_q(restart_req)
  );

  assign shutdown = latched_off | pulse_q;

  // R9: a fault in the same cycle as the S5 release causes no shutdown
  a_r9_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
    release_r |=> !shutdown);
  // R4: a retry shutdown lasts one cycle unless the block latches
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !latched_off) |=> !(shutdown && !latched_off && $past(ev) != EV_COUNTED));
endmodule

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int NUV = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NUV-1:0] uv_flags = '0;
  logic           oc_core = 1'b0, ov_core = 1'b0, ov_term = 1'b0, therm_hot = 1'b0;
  logic           slp_s5_n = 1'b1, ss_tick = 1'b0;
  logic           shutdown, restart_req, latched_off;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic o_sd, o_lat, o_rs;

  always #2 clk = ~clk;

  fault_supervisor #(.NUM_UV(NUV)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_flags(uv_flags), .oc_core(oc_core),
    .ov_core(ov_core), .ov_term(ov_term), .therm_hot(therm_hot),
    .slp_s5_n(slp_s5_n), .ss_tick(ss_tick), .shutdown(shutdown),
    .restart_req(restart_req), .latched_off(latched_off)
  );

  // Behavioural reference model
  int m_lat, m_shut, m_rs, m_cnt, m_tmr;
  logic [NUV-1:0] p_uv;
  logic p_oc, p_ovc, p_ovt, p_hot, p_s5;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 0; m_shut = 0; m_rs = 0; m_cnt = 0; m_tmr = 0;
      p_uv = '0; p_oc = 0; p_ovc = 0; p_ovt = 0; p_hot = 0; p_s5 = 1;
    end else begin
      bit rel, hard, cf, acc, lim;
      int lnx;
      rel  = slp_s5_n && !p_s5;
      hard = (ov_core && !p_ovc) || (ov_term && !p_ovt) || (therm_hot && !p_hot);
      cf   = (|(uv_flags & ~p_uv)) || (oc_core && !p_oc);
      acc  = cf && !hard && !rel && (m_lat == 0);
      lim  = acc && (m_cnt == 3);
      lnx  = rel ? 0 : ((m_lat != 0 || hard || lim) ? 1 : 0);
      m_rs   = (m_shut != 0 && lnx == 0) ? 1 : 0;
      m_shut = (acc && !lim) ? 1 : 0;
      if (rel) begin m_cnt = 0; m_tmr = 0; end
      else if (acc) begin m_cnt = (m_cnt < 4) ? m_cnt + 1 : 4; m_tmr = 0; end
      else if (ss_tick && m_cnt != 0 && m_lat == 0) begin
        if (m_tmr + 1 == 9) begin m_cnt = 0; m_tmr = 0; end
        else m_tmr = m_tmr + 1;
      end
      m_lat = lnx;
      p_uv = uv_flags; p_oc = oc_core; p_ovc = ov_core; p_ovt = ov_term;
      p_hot = therm_hot; p_s5 = slp_s5_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (latched_off !== (m_lat != 0) || shutdown !== (m_lat != 0 || m_shut != 0) ||
          restart_req !== (m_rs != 0)) begin
        fails++;
        $display("FAIL R2/R3/R4 model compare: got sd=%b rs=%b lat=%b exp sd=%0d rs=%0d lat=%0d",
                 shutdown, restart_req, latched_off, (m_lat != 0 || m_shut != 0), m_rs, m_lat);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // One counted fault: sel < NUV picks a UV bit, sel == NUV picks over-current.
  task automatic hit(input int sel);
    if (sel < NUV) uv_flags[sel] = 1'b1; else oc_core = 1'b1;
    cyc(1);
    o_sd = shutdown; o_lat = latched_off;
    uv_flags = '0; oc_core = 1'b0;
    cyc(1);
    o_rs = restart_req;
    cyc(2);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin ss_tick = 1'b1; cyc(1); ss_tick = 1'b0; cyc(1); end
  endtask

  task automatic s5_cycle();
    slp_s5_n = 1'b0; cyc(2); slp_s5_n = 1'b1; cyc(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    finish_run();
  end

  initial begin
    cyc(3);
    chk(shutdown == 0 && restart_req == 0 && latched_off == 0, "R1 reset outputs",
        {shutdown, restart_req, latched_off}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R4 first counted fault
    hit(0);
    chk(o_sd == 1 && o_lat == 0, "R4 shutdown pulse", o_sd, 1);
    chk(o_rs == 1, "R4 restart follows", o_rs, 1);
    chk(shutdown == 0 && restart_req == 0, "R4 pulses end", shutdown, 0);

    // R7 held flag counts once
    uv_flags[1] = 1'b1;
    cyc(2);
    cyc(4);
    chk(shutdown == 0 && restart_req == 0, "R7 held flag no retrigger", shutdown, 0);
    uv_flags[1] = 1'b0;
    cyc(2);

    hit(NUV);
    chk(o_rs == 1 && o_lat == 0, "R4 over-current retry", o_rs, 1);
    hit(2);
    chk(o_lat == 1, "R5 fourth fault latches", o_lat, 1);
    chk(o_rs == 0, "R5 no restart at limit", o_rs, 0);

    // R3 latch hold and release
    hit(3);
    chk(latched_off == 1 && o_rs == 0, "R3 faults ignored when latched", o_rs, 0);
    slp_s5_n = 1'b0; cyc(3);
    chk(latched_off == 1, "R3 still latched in S5", latched_off, 1);
    slp_s5_n = 1'b1; cyc(1);
    chk(latched_off == 0 && shutdown == 0, "R3 release clears", latched_off, 0);
    cyc(1);
    for (int i = 0; i < 3; i++) begin
      hit(i);
      chk(o_lat == 0, "R3 count cleared by release", o_lat, 0);
    end
    // R6 eight ticks are not a full window
    ticks(8);
    hit(4);
    chk(o_lat == 1, "R6 eight ticks keep count", o_lat, 1);
    s5_cycle();

    // R6 nine ticks clear the count
    for (int i = 0; i < 3; i++) hit(i);
    ticks(9);
    for (int i = 0; i < 3; i++) begin
      hit(NUV);
      chk(o_lat == 0, "R6 window cleared count", o_lat, 0);
    end
    hit(0);
    chk(o_lat == 1, "R6 count resumes from zero", o_lat, 1);
    s5_cycle();

    // R6 a fault restarts the window
    hit(0); ticks(5); hit(1); ticks(5); hit(2); hit(3);
    chk(o_lat == 1, "R6 fault resets timer", o_lat, 1);
    s5_cycle();

    // R2 each latching source
    for (int k = 0; k < 3; k++) begin
      if (k == 0) ov_core = 1'b1; else if (k == 1) ov_term = 1'b1; else therm_hot = 1'b1;
      cyc(1);
      chk(latched_off == 1 && shutdown == 1, "R2 immediate latch", latched_off, 1);
      cyc(1);
      chk(restart_req == 0, "R2 no restart", restart_req, 0);
      ov_core = 1'b0; ov_term = 1'b0; therm_hot = 1'b0;
      cyc(2);
      s5_cycle();
    end

    // R8 latching fault beats counted fault
    ov_term = 1'b1; uv_flags[0] = 1'b1;
    cyc(1);
    chk(latched_off == 1, "R8 latch wins", latched_off, 1);
    cyc(1);
    chk(restart_req == 0, "R8 no restart", restart_req, 0);
    ov_term = 1'b0; uv_flags = '0;
    cyc(2);
    s5_cycle();

    // R9 fault coinciding with S5 release is ignored
    slp_s5_n = 1'b0; cyc(2);
    slp_s5_n = 1'b1; uv_flags[4] = 1'b1;
    cyc(1);
    chk(shutdown == 0, "R9 release beats fault", shutdown, 0);
    cyc(1);
    chk(restart_req == 0, "R9 no restart", restart_req, 0);
    uv_flags = '0;
    cyc(3);

    finish_run();
  end
endmodule